// File: doc/BRIEF.md
# Serial LCD Host Port with Display Memory

This block is the host-facing serial port of a segment LCD controller. A host selects it with an active-low chip select and clocks bits in on a write strobe. A separate read strobe, in the four-wire form, clocks bits out on a data line that the block drives only while it is returning data. In the three-wire form the read strobe is simply held high. The first three bits after chip select falls form a mode code. That code selects either a configuration-command stream or one of three data transfers against a 32-word by 4-bit display memory: store, fetch, or fetch-then-store.

The mode code is sent only once per chip-select window. After it, commands, or data nibbles after a single address, may follow back to back with no new code. The memory address steps by one after every nibble and wraps at the top. Each command is delivered to the rest of the chip as a one-cycle valid pulse carrying its 8-bit code. The LCD scan logic reads the memory through its own independent port.

All strobes, chip select and the input data bit are brought into the system clock domain through a two-flop synchroniser before any edge is detected. Host strobes must therefore stay in each level for several system clock periods.

Top module: `lcd_serial_if`

## Requirements
- R1: After reset `data_oe` and `cmd_valid` are low and every display word reads 0 on the scan port.
- R2: Bits are taken on each rising edge of `wr_n`. The first three bits, most significant first, select the mode: 100 command, 101 store, 110 fetch, 111 fetch-then-store. A code whose first bit is 0 makes the rest of the window ignored, so memory is unchanged and no command pulse occurs.
- R3: In command mode each command is 9 bits: an 8-bit code sent most significant bit first, then one don't-care bit. On the ninth bit `cmd_valid` pulses for one cycle with the code on `cmd_code`. Further commands follow in the same window without a new mode code.
- R4: In the three data modes the mode code is followed by a 6-bit address, most significant bit first, whose top bit is ignored.
- R5: In store mode each nibble is sent least significant bit first and written to the current address after its fourth bit. The address then increments and wraps from 31 to 0.
- R6: In fetch mode `data_oe` is high, and each falling edge of `rd_n` puts the next bit of the current word on `data_out`, least significant first. After four bits the address increments.
- R7: In fetch-then-store mode each word is first fetched on four `rd_n` falling edges, then replaced by a nibble stored on four `wr_n` rising edges. Only after the store does the address increment.
- R8: Raising `cs_n` ends the operation, releases `data_oe` and discards any partial command. The next window must start with a new mode code.
- R9: Strobes that do not belong to the current phase have no effect. Write pulses during a fetch leave memory and the fetch address unchanged. Read pulses in store mode leave `data_oe` low.
- R10: `scan_data` always shows the memory word at `scan_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| wr_n | input | 1 | Host write strobe; bit taken on rising edge |
| rd_n | input | 1 | Host read strobe; bit driven on falling edge |
| data_in | input | 1 | Serial data from host |
| data_out | output | 1 | Serial data to host |
| data_oe | output | 1 | High while the block owns the data line |
| cmd_valid | output | 1 | One-cycle pulse per decoded command |
| cmd_code | output | 8 | Code of the last decoded command |
| scan_addr | input | 5 | Scan-side memory address |
| scan_data | output | 4 | Scan-side memory word |

## Verification
Some properties are checked on every cycle. `cmd_valid` never lasts two cycles. A chip-select release always drops `data_oe` on the next cycle. Memory writes occur only right after a write-strobe edge, and each write moves the address by one modulo 32. `data_out` changes only after a read-strobe edge. The bench scenarios are needed for the rest: the mode-code decode, the bit orders, the address top-bit masking, the wrap from 31 to 0, the fetch-then-store interleave, the discarding of a partial command, and the ignoring of strobes outside their phase.

// File: rtl/lcdsp_pkg.sv
// Shared types and mode codes for the serial LCD host port.
// Assumes 3-bit mode codes sent most significant bit first.
package lcdsp_pkg;
    localparam logic [2:0] ID_CMD   = 3'b100;
    localparam logic [2:0] ID_STORE = 3'b101;
    localparam logic [2:0] ID_FETCH = 3'b110;
    localparam logic [2:0] ID_RMW   = 3'b111;

    typedef enum logic [2:0] {
        ST_ID, ST_ADDR, ST_CMD, ST_WR, ST_RD, ST_RMW_RD, ST_RMW_WR, ST_IGN
    } sp_state_t;

    typedef enum logic [1:0] {
        M_STORE, M_FETCH, M_RMW
    } sp_mode_t;
endpackage

// File: rtl/lcdsp_sync.sv
// Multi-bit level synchroniser: STAGES flops per bit into clk domain.
// Assumes each bit is an independent, slowly changing level.
module lcdsp_sync #(
    parameter int N = 4,
    parameter int STAGES = 2,
    parameter logic [N-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [N-1:0] chain [STAGES];

    // First stage captures the asynchronous inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= RST_VAL;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Further stages settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lcdsp_edge.sv
// Single-bit edge detector on a synchronised level; RISE picks the edge.
// Assumes the level idles high (strobes are active low).
module lcdsp_edge #(
    parameter bit RISE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic pulse
);
    logic prev;

    // Remember last level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b1;
        else        prev <= lvl;
    end

    if (RISE) begin : g_rise
        assign pulse = lvl & ~prev;
    end else begin : g_fall
        assign pulse = ~lvl & prev;
    end
endmodule

// File: rtl/lcdsp_ram.sv
// Display memory: one write port, one sequencer read port, one scan port.
// Assumes reads are combinational and the write is synchronous.
module lcdsp_ram #(
    parameter int AW = 5,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [AW-1:0] scan_addr,
    output logic [DW-1:0] scan_data
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    // Clear on reset, otherwise store on write enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata     = mem[addr];
    assign scan_data = mem[scan_addr];
endmodule

// File: rtl/lcdsp_seq.sv
// Protocol sequencer: decodes the mode code, address, commands and nibbles.
// Assumes strobe events are single-cycle pulses in the clk domain and that
// cs_hi is the synchronised deselect level.
module lcdsp_seq
    import lcdsp_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 4,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_hi,
    input  logic          wr_rise,
    input  logic          rd_fall,
    input  logic          din,
    input  logic [DW-1:0] ram_rdata,
    output logic          ram_we,
    output logic [AW-1:0] ram_addr,
    output logic [DW-1:0] ram_wdata,
    output logic          data_out,
    output logic          data_oe,
    output logic          cmd_valid,
    output logic [CW-1:0] cmd_code
);
    localparam int ADDR_BITS = AW + 1;
    localparam int BC_W      = $clog2(CW + 2);
    localparam logic [BC_W-1:0] ID_LAST   = BC_W'(2);
    localparam logic [BC_W-1:0] ADDR_LAST = BC_W'(ADDR_BITS - 1);
    localparam logic [BC_W-1:0] CMD_LAST  = BC_W'(CW);
    localparam logic [BC_W-1:0] NIB_LAST  = BC_W'(DW - 1);

    sp_state_t       state;
    sp_mode_t        mode;
    logic [BC_W-1:0] bcnt;
    logic [CW-1:0]   sh;
    logic [DW-1:0]   wbuf;
    logic [2:0]      id_word;
    logic [DW-1:0]   nib_next;

    assign id_word  = {sh[1:0], din};
    assign nib_next = {din, wbuf[DW-1:1]};

    // Main protocol state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_ID;
            mode      <= M_STORE;
            bcnt      <= '0;
            sh        <= '0;
            wbuf      <= '0;
            ram_we    <= 1'b0;
            ram_addr  <= '0;
            ram_wdata <= '0;
            data_out  <= 1'b0;
            data_oe   <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_code  <= '0;
        end else begin
            cmd_valid <= 1'b0;
            ram_we    <= 1'b0;
            if (ram_we) ram_addr <= ram_addr + 1'b1;
            if (cs_hi) begin
                state   <= ST_ID;
                bcnt    <= '0;
                data_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ID: if (wr_rise) begin
                        sh   <= {sh[CW-2:0], din};
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == ID_LAST) begin
                            bcnt <= '0;
                            case (id_word)
                                ID_CMD:   state <= ST_CMD;
                                ID_STORE: begin state <= ST_ADDR; mode <= M_STORE; end
                                ID_FETCH: begin state <= ST_ADDR; mode <= M_FETCH; end
                                ID_RMW:   begin state <= ST_ADDR; mode <= M_RMW;   end
                                default:  state <= ST_IGN;
                            endcase
                        end
                    end
                    ST_ADDR: if (wr_rise) begin
                        sh   <= {sh[CW-2:0], din};
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == ADDR_LAST) begin
                            bcnt     <= '0;
                            ram_addr <= {sh[AW-2:0], din};
                            case (mode)
                                M_STORE: state <= ST_WR;
                                M_FETCH: begin state <= ST_RD;     data_oe <= 1'b1; end
                                default: begin state <= ST_RMW_RD; data_oe <= 1'b1; end
                            endcase
                        end
                    end
                    ST_CMD: if (wr_rise) begin
                        sh   <= {sh[CW-2:0], din};
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == CMD_LAST) begin
                            bcnt      <= '0;
                            cmd_code  <= sh;
                            cmd_valid <= 1'b1;
                        end
                    end
                    ST_WR, ST_RMW_WR: if (wr_rise) begin
                        wbuf <= nib_next;
                        bcnt <= bcnt + 1'b1;
                        if (bcnt == NIB_LAST) begin
                            bcnt      <= '0;
                            ram_wdata <= nib_next;
                            ram_we    <= 1'b1;
                            if (state == ST_RMW_WR) begin
                                state   <= ST_RMW_RD;
                                data_oe <= 1'b1;
                            end
                        end
                    end
                    ST_RD, ST_RMW_RD: if (rd_fall) begin
                        data_out <= ram_rdata[bcnt[$clog2(DW)-1:0]];
                        bcnt     <= bcnt + 1'b1;
                        if (bcnt == NIB_LAST) begin
                            bcnt <= '0;
                            if (state == ST_RD) begin
                                ram_addr <= ram_addr + 1'b1;
                            end else begin
                                state   <= ST_RMW_WR;
                                data_oe <= 1'b0;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/lcd_serial_if.sv
// Top: serial host port plus 32x4 display memory for a segment LCD.
// Assumes host strobes hold each level for several clk periods.
module lcd_serial_if #(
    parameter int AW = 5,
    parameter int DW = 4,
    parameter int CW = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          wr_n,
    input  logic          rd_n,
    input  logic          data_in,
    output logic          data_out,
    output logic          data_oe,
    output logic          cmd_valid,
    output logic [CW-1:0] cmd_code,
    input  logic [AW-1:0] scan_addr,
    output logic [DW-1:0] scan_data
);
    localparam int NSYNC = 4;

    logic [NSYNC-1:0] lv;
    logic             wr_rise, rd_fall;
    logic             ram_we;
    logic [AW-1:0]    ram_addr;
    logic [DW-1:0]    ram_wdata, ram_rdata;

    lcdsp_sync #(.N(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n, wr_n, rd_n, data_in}), .q(lv)
    );

    lcdsp_edge #(.RISE(1'b1)) u_wr_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lv[2]), .pulse(wr_rise)
    );

    lcdsp_edge #(.RISE(1'b0)) u_rd_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lv[1]), .pulse(rd_fall)
    );

    lcdsp_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk(clk), .rst_n(rst_n), .cs_hi(lv[3]),
        .wr_rise(wr_rise), .rd_fall(rd_fall), .din(lv[0]),
        .ram_rdata(ram_rdata), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .data_out(data_out), .data_oe(data_oe),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code)
    );

    lcdsp_ram #(.AW(AW), .DW(DW)) u_ram (
        .clk(clk), .rst_n(rst_n), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_rdata),
        .scan_addr(scan_addr), .scan_data(scan_data)
    );
endmodule

// File: rtl/lcd_serial_if_chk.sv
// Checker bound into the top: cycle-level protocol properties.
// Assumes the internal strobe pulses and memory port names of the top.
module lcd_serial_if_chk #(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_hi,
    input logic          wr_rise,
    input logic          rd_fall,
    input logic          ram_we,
    input logic [AW-1:0] ram_addr,
    input logic          data_out,
    input logic          data_oe,
    input logic          cmd_valid
);
    // R3: a command pulse lasts exactly one cycle.
    p_cmd_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R8: deselect always releases the data line.
    p_cs_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_hi |=> !data_oe);

    // R5: memory writes only follow a write-strobe edge.
    p_we_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(wr_rise));

    // R5: each write advances the address by one, modulo the depth.
    p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |=> ram_addr == $past(ram_addr) + 1'b1);

    // R6: the output bit changes only after a read-strobe edge.
    p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fall |=> $stable(data_out));
endmodule

bind lcd_serial_if lcd_serial_if_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_hi(lv[3]), .wr_rise(wr_rise),
    .rd_fall(rd_fall), .ram_we(ram_we), .ram_addr(ram_addr),
    .data_out(data_out), .data_oe(data_oe), .cmd_valid(cmd_valid)
);

// File: tb/lcd_serial_if_test.sv
module lcd_serial_if_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, data_in = 1'b0;
    logic       data_out, data_oe, cmd_valid;
    logic [7:0] cmd_code;
    logic [4:0] scan_addr = '0;
    logic [3:0] scan_data;

    int tests = 0, fails = 0;
    int ncmd = 0;
    logic [7:0] cmd_log [16];
    bit done = 0;

    always #2.5 clk = ~clk;

    lcd_serial_if uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .scan_addr(scan_addr), .scan_data(scan_data)
    );

    // Log every command pulse seen at the ports.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (ncmd < 16) cmd_log[ncmd] = cmd_code;
            ncmd++;
        end
    end

    // {address 6 bits, nibble}; read back at address with top bit cleared.
    localparam logic [9:0] VEC [6] = '{
        {6'd0,  4'h5}, {6'd1,  4'hA}, {6'h23, 4'hC},
        {6'd31, 4'h7}, {6'd17, 4'h0}, {6'd8,  4'hF}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_bit(input logic b);
        @(negedge clk); data_in = b; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic send(input logic [8:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) wr_bit(v[i]);
    endtask

    task automatic send_nib(input logic [3:0] d);
        for (int i = 0; i < 4; i++) wr_bit(d[i]);
    endtask

    task automatic get_nib(output logic [3:0] d, output logic oe);
        oe = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); rd_n = 1'b0;
            repeat (6) @(negedge clk);
            d[i] = data_out;
            oe = oe & data_oe;
            rd_n = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic cs_low();
        @(negedge clk); cs_n = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic cs_high();
        @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
    endtask

    task automatic scan(input logic [4:0] a, output logic [3:0] d);
        @(negedge clk); scan_addr = a; #1 d = scan_data;
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [3:0] d;
        logic oe;
        int base;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(data_oe == 1'b0, "R1 oe", data_oe, 0);
        check(cmd_valid == 1'b0, "R1 cmd_valid", cmd_valid, 0);
        scan(5'd0, d);  check(d == 4'h0, "R1 word0", d, 0);
        scan(5'd31, d); check(d == 4'h0, "R1 word31", d, 0);

        // R2 R4 R5 R6: table of store then fetch
        foreach (VEC[k]) begin
            cs_low(); send(9'b101, 3); send({3'b0, VEC[k][9:4]}, 6); send_nib(VEC[k][3:0]); cs_high();
            cs_low(); send(9'b110, 3); send({4'b0, VEC[k][8:4]}, 6);
            get_nib(d, oe); cs_high();
            check(d == VEC[k][3:0], "R4/R5/R6 fetch", d, VEC[k][3:0]);
            check(oe == 1'b1, "R6 oe during fetch", oe, 1);
        end
        scan(5'd3, d); check(d == 4'hC, "R4 top address bit ignored", d, 4'hC);

        // R5 successive store with wrap 30,31,0
        cs_low(); send(9'b101, 3); send(9'd30, 6);
        send_nib(4'h1); send_nib(4'h2); send_nib(4'h3); cs_high();
        scan(5'd30, d); check(d == 4'h1, "R5 word30", d, 1);
        scan(5'd31, d); check(d == 4'h2, "R5 word31", d, 2);
        scan(5'd0, d);  check(d == 4'h3, "R5 wrap to 0", d, 3);

        // R6 successive fetch crosses words
        cs_low(); send(9'b110, 3); send(9'd30, 6);
        get_nib(d, oe); check(d == 4'h1, "R6 fetch word30", d, 1);
        get_nib(d, oe); check(d == 4'h2, "R6 fetch word31 auto-inc", d, 2);
        cs_high();

        // R3 two successive commands in one window
        base = ncmd;
        cs_low(); send(9'b100, 3); send({8'hA5, 1'b0}, 9); send({8'h3C, 1'b1}, 9); cs_high();
        check(ncmd == base + 2, "R3 pulse count", ncmd - base, 2);
        check(cmd_log[base] == 8'hA5, "R3 first code", cmd_log[base], 8'hA5);
        check(cmd_log[base+1] == 8'h3C, "R3 second code", cmd_log[base+1], 8'h3C);

        // R8 partial command discarded, new window needs its own code
        base = ncmd;
        cs_low(); send(9'b100, 3); send(9'b1010, 4); cs_high();
        cs_low(); send(9'b101, 3); send(9'd10, 6); send_nib(4'h9); cs_high();
        check(ncmd == base, "R8 no pulse from partial command", ncmd - base, 0);
        scan(5'd10, d); check(d == 4'h9, "R8 new window stores", d, 9);

        // R9 write pulses during fetch are ignored
        cs_low(); send(9'b110, 3); send(9'd10, 6);
        send_nib(4'h0); get_nib(d, oe);
        check(d == 4'h9, "R9 fetch address unchanged by writes", d, 9);
        // R8 deselect releases the line
        @(negedge clk); cs_n = 1'b1; repeat (6) @(negedge clk);
        check(data_oe == 1'b0, "R8 oe released", data_oe, 0);
        scan(5'd10, d); check(d == 4'h9, "R9 memory unchanged", d, 9);

        // R9 read pulses in store mode keep oe low
        cs_low(); send(9'b101, 3); send(9'd12, 6);
        @(negedge clk); rd_n = 1'b0; repeat (6) @(negedge clk);
        check(data_oe == 1'b0, "R9 oe low in store mode", data_oe, 0);
        rd_n = 1'b1; repeat (4) @(negedge clk);
        send_nib(4'h6); send_nib(4'h2); cs_high();

        // R7 fetch-then-store on words 12 and 13
        cs_low(); send(9'b111, 3); send(9'd12, 6);
        get_nib(d, oe); check(d == 4'h6, "R7 fetch word12", d, 6);
        send_nib(4'hF);
        get_nib(d, oe); check(d == 4'h2, "R7 fetch word13", d, 2);
        send_nib(4'h1); cs_high();
        scan(5'd12, d); check(d == 4'hF, "R7 store word12", d, 15);
        scan(5'd13, d); check(d == 4'h1, "R7 store word13", d, 1);

        // R2 invalid code ignores the rest of the window
        base = ncmd;
        cs_low(); send(9'b011, 3); send(9'b101, 3); send(9'd20, 6); send_nib(4'h7); cs_high();
        scan(5'd20, d); check(d == 4'h0, "R2 invalid code no store", d, 0);
        check(ncmd == base, "R2 invalid code no command", ncmd - base, 0);

        // R10 scan port follows address
        scan(5'd17, d); check(d == 4'h0, "R10 scan word17", d, 0);
        scan(5'd8, d);  check(d == 4'hF, "R10 scan word8", d, 15);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule